// File: doc/BRIEF.md
# Control Slot Pool Allocator

This block manages a small pool of display control slots, up to eight of them. Every slot carries two status bits: one marks it in use, and one marks it set aside for the two interfaces that run as a synchronised pair. A client asks for a slot by presenting an interface number. The block picks a slot by a fixed search order and answers one cycle later with either a slot index or a failure. A separate release port returns a slot to the pool.

Requests for interface 1 or 2 look first among the set-aside slots. All other requests look first among the ordinary slots. When the preferred group has no free slot, the block searches the other group and raises a warning flag alongside the grant. A revision input, sampled in the first clock after reset, decides whether slots 0 and 1 start out set aside and whether the paired single-flush capability is reported. The status of every slot can be read at any time on a flat readout bus.

Top module: `ctl_pool_alloc`

## Requirements
- R1: `status_o` holds two bits per slot, slot i at bits [2i+1:2i], with bit 2i meaning in use and bit 2i+1 meaning set aside.
- R2: After reset, `req_ready_o` stays low for one clock while `rev_i` is sampled. If `rev_i` >= 3, slots 0 and 1 get their set-aside bit and `single_flush_o` goes high. Otherwise every slot status is zero and `single_flush_o` is low.
- R3: A request with `req_intf_i` equal to 1 or 2 prefers a free slot with the set-aside bit set. Any other interface number prefers a free slot with the set-aside bit clear.
- R4: Within a search pass, the lowest-indexed matching slot is granted.
- R5: If no slot matches the preferred pattern, a second pass is made with the set-aside expectation inverted. A grant from that pass asserts `fallback_o` together with `grant_valid_o`.
- R6: If neither pass finds a free slot, `fail_o` pulses and no slot status changes.
- R7: A grant sets the slot's in-use bit and leaves its set-aside bit unchanged.
- R8: Slots with index at or above `N_POP` are never granted and never change status.
- R9: A request is accepted when `req_valid_i` and `req_ready_o` are both high. In the next cycle exactly one of `grant_valid_o` and `fail_o` is high for one cycle, and `grant_id_o` holds the slot when granted. No result appears without an accepted request.
- R10: A release clears only the in-use bit of the named slot. Releasing a free slot or an unpopulated slot has no effect.
- R11: When a release and a request are in the same cycle, the release is applied first, so the released slot can be granted in that same cycle.
- R12: Once `req_ready_o` is high, the set-aside bits and `single_flush_o` do not change until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rev_i | input | REV_W | Hardware revision, sampled in the first clock after reset |
| req_valid_i | input | 1 | Request strobe |
| req_ready_o | output | 1 | Request can be accepted |
| req_intf_i | input | INTF_W | Interface number of the requester |
| rel_valid_i | input | 1 | Release strobe |
| rel_id_i | input | IDW | Slot to release |
| grant_valid_o | output | 1 | One-cycle pulse: slot granted |
| grant_id_o | output | IDW | Granted slot index |
| fail_o | output | 1 | One-cycle pulse: no slot available |
| fallback_o | output | 1 | Grant came from the non-preferred group |
| single_flush_o | output | 1 | Paired single-flush capability present |
| status_o | output | 2*N_SLOTS | Per-slot status readout |

## Verification
The grant, failure and fallback outputs are due in the cycle after the edge that accepts a request. The slot status readout changes on that same edge, and the ready flag rises one edge after reset is released. The bench drives inputs on the falling edge, and a scoreboard entry is queued at that moment. The monitor samples two nanoseconds after the next rising edge and pops exactly one entry per accepted request. Any result pulse with no entry queued counts as a failure. Status readouts are compared against a bench-side model on a later falling edge, once the inputs are idle, so each release or grant has reached the registers before the comparison.

// File: rtl/ctl_pool_pkg.sv
package ctl_pool_pkg;
  localparam int unsigned STAT_W = 2;
  localparam int unsigned BUSY_B = 0;
  localparam int unsigned RSV_B  = 1;
  localparam int unsigned RSV_SLOTS = 2;

  typedef struct packed {
    logic rsv;
    logic busy;
  } slot_stat_t;
endpackage

// File: rtl/ctl_pool_search.sv
module ctl_pool_search
  import ctl_pool_pkg::*;
#(
  parameter int unsigned N_SLOTS = 8,
  parameter int unsigned N_POP   = 6,
  parameter int unsigned IDW     = 3
) (
  input  logic [STAT_W*N_SLOTS-1:0] stat_i,
  input  logic                      want_rsv_i,
  output logic                      found_o,
  output logic [IDW-1:0]            idx_o
);
  logic [N_SLOTS-1:0] hit;

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_hit
    if (g < N_POP) begin : g_pop
      slot_stat_t s;
      assign s      = stat_i[STAT_W*g +: STAT_W];
      assign hit[g] = ~s.busy & (s.rsv == want_rsv_i);
    end else begin : g_unpop
      assign hit[g] = 1'b0;
    end
  end

  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = N_SLOTS - 1; i >= 0; i--) begin
      if (hit[i]) idx_o = IDW'(i);
    end
  end

  assign found_o = |hit;
endmodule

// File: rtl/ctl_pool_status.sv
module ctl_pool_status
  import ctl_pool_pkg::*;
#(
  parameter int unsigned N_SLOTS = 8,
  parameter int unsigned N_POP   = 6,
  parameter int unsigned IDW     = 3,
  parameter int unsigned REV_W   = 4,
  parameter int unsigned SF_REV  = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [REV_W-1:0]          rev_i,
  input  logic                      rel_en_i,
  input  logic [IDW-1:0]            rel_id_i,
  input  logic                      grant_en_i,
  input  logic [IDW-1:0]            grant_id_i,
  output logic                      init_o,
  output logic                      sflush_o,
  output logic [STAT_W*N_SLOTS-1:0] stat_o,
  output logic [STAT_W*N_SLOTS-1:0] stat_rel_o
);
  logic [STAT_W*N_SLOTS-1:0] stat_q, stat_d, stat_init;
  logic                      init_q, sflush_q;
  logic                      rev_ok;

  assign rev_ok = (rev_i >= REV_W'(SF_REV));

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    logic rel_hit, gnt_hit;
    if (g < N_POP) begin : g_pop
      assign rel_hit = rel_en_i   && (rel_id_i   == IDW'(g));
      assign gnt_hit = grant_en_i && (grant_id_i == IDW'(g));
    end else begin : g_unpop
      assign rel_hit = 1'b0;
      assign gnt_hit = 1'b0;
    end
    // release applied ahead of the search
    assign stat_rel_o[STAT_W*g+BUSY_B] = stat_q[STAT_W*g+BUSY_B] & ~rel_hit;
    assign stat_rel_o[STAT_W*g+RSV_B]  = stat_q[STAT_W*g+RSV_B];
    assign stat_d[STAT_W*g+BUSY_B]     = stat_rel_o[STAT_W*g+BUSY_B] | gnt_hit;
    assign stat_d[STAT_W*g+RSV_B]      = stat_q[STAT_W*g+RSV_B];
    assign stat_init[STAT_W*g+BUSY_B]  = 1'b0;
    if (g < RSV_SLOTS && g < N_POP) begin : g_rsv
      assign stat_init[STAT_W*g+RSV_B] = rev_ok;
    end else begin : g_norsv
      assign stat_init[STAT_W*g+RSV_B] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q   <= '0;
      init_q   <= 1'b1;
      sflush_q <= 1'b0;
    end else if (init_q) begin
      stat_q   <= stat_init;
      init_q   <= 1'b0;
      sflush_q <= rev_ok;
    end else begin
      stat_q   <= stat_d;
    end
  end

  assign stat_o   = stat_q;
  assign init_o   = init_q;
  assign sflush_o = sflush_q;
endmodule

// File: rtl/ctl_pool_alloc.sv
module ctl_pool_alloc
  import ctl_pool_pkg::*;
#(
  parameter int unsigned N_SLOTS = 8,
  parameter int unsigned N_POP   = 6,
  parameter int unsigned INTF_W  = 4,
  parameter int unsigned REV_W   = 4,
  parameter int unsigned SF_REV  = 3,
  localparam int unsigned IDW    = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [REV_W-1:0]          rev_i,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic [INTF_W-1:0]         req_intf_i,
  input  logic                      rel_valid_i,
  input  logic [IDW-1:0]            rel_id_i,
  output logic                      grant_valid_o,
  output logic [IDW-1:0]            grant_id_o,
  output logic                      fail_o,
  output logic                      fallback_o,
  output logic                      single_flush_o,
  output logic [STAT_W*N_SLOTS-1:0] status_o
);
  logic [STAT_W*N_SLOTS-1:0] stat_rel;
  logic                      init;
  logic                      req_fire, pair_intf;
  logic                      pref_found, alt_found, grant_en;
  logic [IDW-1:0]            pref_idx, alt_idx, grant_id;
  logic                      gv_q, fail_q, fb_q;
  logic [IDW-1:0]            gid_q;

  assign req_ready_o = ~init;
  assign req_fire    = req_valid_i & req_ready_o;
  assign pair_intf   = (req_intf_i == INTF_W'(1)) || (req_intf_i == INTF_W'(2));

  ctl_pool_status #(
    .N_SLOTS(N_SLOTS), .N_POP(N_POP), .IDW(IDW), .REV_W(REV_W), .SF_REV(SF_REV)
  ) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rev_i      (rev_i),
    .rel_en_i   (rel_valid_i & ~init),
    .rel_id_i   (rel_id_i),
    .grant_en_i (grant_en),
    .grant_id_i (grant_id),
    .init_o     (init),
    .sflush_o   (single_flush_o),
    .stat_o     (status_o),
    .stat_rel_o (stat_rel)
  );

  ctl_pool_search #(.N_SLOTS(N_SLOTS), .N_POP(N_POP), .IDW(IDW)) u_pref (
    .stat_i     (stat_rel),
    .want_rsv_i (pair_intf),
    .found_o    (pref_found),
    .idx_o      (pref_idx)
  );

  ctl_pool_search #(.N_SLOTS(N_SLOTS), .N_POP(N_POP), .IDW(IDW)) u_alt (
    .stat_i     (stat_rel),
    .want_rsv_i (~pair_intf),
    .found_o    (alt_found),
    .idx_o      (alt_idx)
  );

  assign grant_en = req_fire & (pref_found | alt_found);
  assign grant_id = pref_found ? pref_idx : alt_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gv_q   <= 1'b0;
      fail_q <= 1'b0;
      fb_q   <= 1'b0;
      gid_q  <= '0;
    end else begin
      gv_q   <= grant_en;
      fail_q <= req_fire & ~pref_found & ~alt_found;
      fb_q   <= req_fire & ~pref_found & alt_found;
      if (grant_en) gid_q <= grant_id;
    end
  end

  assign grant_valid_o = gv_q;
  assign grant_id_o    = gid_q;
  assign fail_o        = fail_q;
  assign fallback_o    = fb_q;
endmodule

// File: rtl/ctl_pool_alloc_chk.sv
module ctl_pool_alloc_chk
  import ctl_pool_pkg::*;
#(
  parameter int unsigned N_SLOTS = 8,
  parameter int unsigned N_POP   = 6,
  parameter int unsigned IDW     = 3
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      req_valid_i,
  input logic                      req_ready_o,
  input logic                      rel_valid_i,
  input logic                      grant_valid_o,
  input logic [IDW-1:0]            grant_id_o,
  input logic                      fail_o,
  input logic                      fallback_o,
  input logic                      single_flush_o,
  input logic [STAT_W*N_SLOTS-1:0] status_o
);
  localparam logic [IDW:0] POP_LIM = (IDW+1)'(N_POP);
  logic [N_SLOTS-1:0] rsv_mask;

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_m
    assign rsv_mask[g] = status_o[STAT_W*g+RSV_B];
  end

  // R9
  one_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (grant_valid_o ^ fail_o));

  // R9
  excl_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_valid_o && fail_o));

  // R8
  grant_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> ({1'b0, grant_id_o} < POP_LIM));

  // R7
  grant_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> status_o[{grant_id_o, 1'b0}]);

  // R5
  fallback_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fallback_o |-> grant_valid_o);

  // R6
  fail_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !$past(rel_valid_i)) |-> $stable(status_o));

  // R12
  rsv_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && $past(req_ready_o)) |-> ($stable(rsv_mask) && $stable(single_flush_o)));
endmodule

bind ctl_pool_alloc ctl_pool_alloc_chk #(
  .N_SLOTS(N_SLOTS), .N_POP(N_POP), .IDW(IDW)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_ready_o    (req_ready_o),
  .rel_valid_i    (rel_valid_i),
  .grant_valid_o  (grant_valid_o),
  .grant_id_o     (grant_id_o),
  .fail_o         (fail_o),
  .fallback_o     (fallback_o),
  .single_flush_o (single_flush_o),
  .status_o       (status_o)
);

// File: tb/tb_ctl_pool_alloc.sv
`timescale 1ns/1ps
module tb_ctl_pool_alloc;
  localparam int N_SLOTS = 8;
  localparam int N_POP   = 6;
  localparam int INTF_W  = 4;
  localparam int REV_W   = 4;
  localparam int IDW     = 3;

  typedef struct {
    bit    gv;
    int    id;
    bit    fb;
    bit    fl;
    string tag;
  } exp_t;

  logic                  clk = 0;
  logic                  rst_n = 0;
  logic [REV_W-1:0]      rev = '0;
  logic                  req_valid = 0;
  logic                  req_ready;
  logic [INTF_W-1:0]     req_intf = '0;
  logic                  rel_valid = 0;
  logic [IDW-1:0]        rel_id = '0;
  logic                  grant_valid, fail, fallback, single_flush;
  logic [IDW-1:0]        grant_id;
  logic [2*N_SLOTS-1:0]  status;

  int   n_chk = 0, n_fail = 0;
  exp_t q[$];
  exp_t e;
  bit [1:0] m[N_SLOTS];

  always #4 clk = ~clk;

  ctl_pool_alloc #(.N_SLOTS(N_SLOTS), .N_POP(N_POP), .INTF_W(INTF_W), .REV_W(REV_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rev_i(rev),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_intf_i(req_intf),
    .rel_valid_i(rel_valid), .rel_id_i(rel_id),
    .grant_valid_o(grant_valid), .grant_id_o(grant_id), .fail_o(fail),
    .fallback_o(fallback), .single_flush_o(single_flush), .status_o(status)
  );

  // monitor
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (q.size() > 0) begin
        e = q.pop_front();
        n_chk++;
        if (grant_valid !== e.gv || fail !== e.fl || fallback !== e.fb ||
            (e.gv && int'(grant_id) != e.id)) begin
          n_fail++;
          $display("FAIL %s: got gv=%0b id=%0d fb=%0b fail=%0b, exp gv=%0b id=%0d fb=%0b fail=%0b",
                   e.tag, grant_valid, grant_id, fallback, fail, e.gv, e.id, e.fb, e.fl);
        end
      end else if (grant_valid || fail) begin
        n_fail++;
        $display("FAIL R9: result pulse without request, gv=%0b fail=%0b, exp 0 0", grant_valid, fail);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h, exp %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int r);
    @(negedge clk);
    rst_n = 0; rev = REV_W'(r);
    req_valid = 0; rel_valid = 0;
    repeat (2) @(negedge clk);
    foreach (m[i]) m[i] = 2'b00;
    if (r >= 3) begin m[0] = 2'b10; m[1] = 2'b10; end
    rst_n = 1;
    #1;
    check(req_ready == 1'b0, "R2 ready low in sample cycle", req_ready, 0);
    @(negedge clk);
    check(req_ready == 1'b1, "R2 ready after sample", req_ready, 1);
    check(single_flush == (r >= 3), "R2 single_flush", single_flush, (r >= 3));
  endtask

  task automatic op(input bit rv, input int intf, input bit lv, input int lid, input string tag);
    exp_t x;
    bit pref, found;
    int id;
    @(negedge clk);
    if (lv && lid < N_POP) m[lid][0] = 1'b0;
    if (rv) begin
      pref = (intf == 1 || intf == 2);
      found = 0; id = 0;
      for (int i = 0; i < N_POP; i++)
        if (!found && m[i][0] == 0 && m[i][1] == pref) begin found = 1; id = i; end
      x.fb = 0;
      if (!found) begin
        for (int i = 0; i < N_POP; i++)
          if (!found && m[i][0] == 0 && m[i][1] == !pref) begin found = 1; id = i; x.fb = 1; end
      end
      x.gv = found; x.fl = !found; x.id = id; x.tag = tag;
      if (found) m[id][0] = 1'b1;
      q.push_back(x);
    end
    req_valid = rv; req_intf = INTF_W'(intf);
    rel_valid = lv; rel_id = IDW'(lid);
    @(negedge clk);
    req_valid = 0; rel_valid = 0;
  endtask

  task automatic chk_status(input string tag);
    logic [2*N_SLOTS-1:0] ex;
    @(negedge clk);
    for (int i = 0; i < N_SLOTS; i++) ex[2*i +: 2] = m[i];
    check(status == ex, tag, status, ex);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run hung, got timeout, exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // revision with set-aside slots
    do_reset(5);
    chk_status("R1 R2 initial status rev5");
    op(1, 1, 0, 0, "R3 pair intf 1 -> reserved slot0");
    op(1, 2, 0, 0, "R3 R4 pair intf 2 -> slot1");
    op(1, 1, 0, 0, "R5 pair intf falls back to slot2");
    op(1, 0, 0, 0, "R3 R4 intf 0 -> slot3");
    op(1, 5, 0, 0, "R4 intf 5 -> slot4");
    op(1, 7, 0, 0, "R4 intf 7 -> slot5");
    chk_status("R7 status after grants");
    op(1, 3, 0, 0, "R6 R8 pool exhausted -> fail");
    chk_status("R6 R8 status unchanged after fail");
    op(1, 0, 1, 4, "R11 release+request same cycle -> slot4");
    chk_status("R11 status after same-cycle reuse");
    op(0, 0, 1, 0, "R10 release slot0");
    chk_status("R10 release keeps reserved bit");
    op(0, 0, 1, 0, "R10 second release");
    op(0, 0, 1, 7, "R10 release unpopulated");
    chk_status("R10 ignored releases");
    op(1, 4, 0, 0, "R5 ordinary intf falls back to reserved slot0");
    chk_status("R7 grant keeps reserved bit");
    op(0, 0, 1, 1, "R10 release slot1");
    op(1, 2, 0, 0, "R3 pair intf 2 reuses slot1");
    chk_status("R12 reserved bits held");
    check(single_flush == 1'b1, "R12 single_flush held", single_flush, 1);
    // old revision: nothing set aside
    do_reset(1);
    chk_status("R2 initial status rev1");
    op(1, 1, 0, 0, "R5 pair intf with no reserved -> slot0 fallback");
    op(1, 0, 0, 0, "R3 intf 0 -> slot1");
    op(1, 2, 1, 0, "R11 release slot0 then pair intf -> slot0");
    chk_status("R7 status rev1");
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R9 all results seen", q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule